// File: doc/BRIEF.md
# Register Command Stream Executor

This block turns a list of 32-bit command words held in a local command RAM into register accesses on a simple request/ready register bus. Software first fills the command RAM through a plain write port, then starts a run by giving a starting word offset, a length in words, a two-bit interrupt code and a trigger choice. The block walks the words from the offset and decodes each command header. It then performs a single write, a read-modify-write, a burst of writes to one fixed register, or a burst of writes to rising addresses. No-ops and unknown opcodes are stepped over one word at a time.

A run ends when the submitted number of words has been consumed. A command cut off by the end of the length is abandoned at that point. On completion the block drops its busy flag and pulses the interrupt code for one cycle. A run may start at once or wait for an external flush strobe. Command RAM addresses wrap modulo the RAM depth, so a program may straddle the end of the RAM.

Top module: `cmd_stream_exec`

## Requirements
- R1: A header word carries the opcode in bits 31:28 and the register byte address in bits 19:0. Bits 27:20 have no effect.
- R2: Opcode 1 (single write) takes two words, header then data, and writes the data to the header address.
- R3: Opcode 2 (read-modify-write) takes three words: header, mask, data. It reads the register. In the next bus request it writes (read value AND mask) OR data to the same address.
- R4: Opcode 3 takes header, count N, then N data words. Each data word is written in turn to the header address.
- R5: Opcode 4 is like opcode 3, but the address rises by 4 after each data word and wraps within 20 bits.
- R6: Opcode 0 (no-op) and every opcode from 5 to 15 consume exactly one word and cause no bus access. Execution continues with the next word.
- R7: A block command with count 0 consumes only its header and count words.
- R8: A run consumes exactly `start_len` words from `start_offset`, wrapping modulo the RAM depth. A command truncated by the end of the length performs only the accesses whose words lie inside the length.
- R9: A bus request holds `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` steady until the cycle in which `reg_ready` is high.
- R10: `busy` rises in the cycle after an accepted start. At completion `busy` falls and `irq` shows the start's interrupt code for exactly one cycle. A zero-length run completes without any bus access. No bus request is raised while `busy` is low.
- R11: With `start_ext_trig` = 1, no command is executed until `ext_flush` is seen high. While the block is idle, `ext_flush` has no effect.
- R12: A start pulse while `busy` is high is ignored. A start in the cycle `irq` pulses is accepted.
- R13: After reset, `busy`, `irq` and `reg_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_we | input | 1 | Command RAM write enable |
| ram_waddr | input | 8 | Command RAM word address |
| ram_wdata | input | 32 | Command RAM write data |
| start | input | 1 | Run start strobe |
| start_offset | input | 8 | First command word of the run |
| start_len | input | 9 | Run length in words |
| start_irq_sel | input | 2 | Interrupt code returned at completion |
| start_ext_trig | input | 1 | 1: wait for ext_flush before executing |
| ext_flush | input | 1 | External trigger strobe |
| busy | output | 1 | Run in progress |
| irq | output | 2 | One-cycle completion pulse carrying the code |
| reg_req | output | 1 | Register bus request |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | 20 | Register byte address |
| reg_wdata | output | 32 | Register write data |
| reg_ready | input | 1 | Request accepted; read data valid |
| reg_rdata | input | 32 | Register read data |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. Two programs are placed at disjoint offsets. The second start is driven in exactly the cycle where busy is first seen low with the interrupt code showing. That run is judged by the register file and write count after both programs, as predicted by the bench model. A read-modify-write read response also shares its cycle with the switch to the write request. This case is judged by the final register value under random ready delays.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int WORD_W = 32;
  localparam int RADDR_W = 20;

  localparam logic [3:0] OP_NOP     = 4'd0;
  localparam logic [3:0] OP_WRITE   = 4'd1;
  localparam logic [3:0] OP_MODIFY  = 4'd2;
  localparam logic [3:0] OP_BLK_FIX = 4'd3;
  localparam logic [3:0] OP_BLK_INC = 4'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_FETCH, S_USE, S_RD, S_BUS, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_HDR, PH_ARG1, PH_ARG2, PH_BLK
  } phase_t;

  function automatic logic [WORD_W-1:0] rmw_merge(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] msk,
                                                  input logic [WORD_W-1:0] val);
    return (cur & msk) | val;
  endfunction
endpackage

// File: rtl/cse_cmd_ram.sv
module cse_cmd_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cse_sequencer.sv
module cse_sequencer
  import cse_pkg::*;
#(
  parameter int AW = 8,
  localparam int LW = AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [AW-1:0]      start_offset,
  input  logic [LW-1:0]      start_len,
  input  logic [1:0]         start_irq_sel,
  input  logic               start_ext_trig,
  input  logic               ext_flush,
  output logic [AW-1:0]      ram_raddr,
  input  logic [WORD_W-1:0]  ram_rdata,
  output logic               busy,
  output logic [1:0]         irq,
  output logic               reg_req,
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0]  reg_wdata,
  input  logic               reg_ready,
  input  logic [WORD_W-1:0]  reg_rdata
);
  seq_state_t          state;
  phase_t              phase;
  logic [AW-1:0]       ptr;
  logic [LW-1:0]       left;
  logic [1:0]          sel;
  logic [3:0]          op;
  logic [RADDR_W-1:0]  addr;
  logic [WORD_W-1:0]   mask_q, data_q, cnt;

  assign ram_raddr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= PH_HDR;
      ptr       <= '0;
      left      <= '0;
      sel       <= '0;
      op        <= OP_NOP;
      addr      <= '0;
      mask_q    <= '0;
      data_q    <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      irq       <= '0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      irq <= '0;
      case (state)
        S_IDLE: if (start) begin
          ptr   <= start_offset;
          left  <= start_len;
          sel   <= start_irq_sel;
          phase <= PH_HDR;
          busy  <= 1'b1;
          state <= start_ext_trig ? S_ARM : S_FETCH;
        end
        S_ARM: if (ext_flush) state <= S_FETCH;
        S_FETCH: begin
          if (left == '0) begin
            state <= S_DONE;
          end else begin
            ptr   <= ptr + 1'b1;
            left  <= left - 1'b1;
            state <= S_USE;
          end
        end
        S_USE: begin
          case (phase)
            PH_HDR: begin
              op    <= ram_rdata[31:28];
              addr  <= ram_rdata[RADDR_W-1:0];
              if (ram_rdata[31:28] != OP_NOP && ram_rdata[31:28] <= OP_BLK_INC)
                phase <= PH_ARG1;
              state <= S_FETCH;
            end
            PH_ARG1: begin
              if (op == OP_WRITE) begin
                reg_req   <= 1'b1;
                reg_we    <= 1'b1;
                reg_addr  <= addr;
                reg_wdata <= ram_rdata;
                phase     <= PH_HDR;
                state     <= S_BUS;
              end else if (op == OP_MODIFY) begin
                mask_q <= ram_rdata;
                phase  <= PH_ARG2;
                state  <= S_FETCH;
              end else begin
                cnt   <= ram_rdata;
                phase <= (ram_rdata == '0) ? PH_HDR : PH_BLK;
                state <= S_FETCH;
              end
            end
            PH_ARG2: begin
              data_q   <= ram_rdata;
              reg_req  <= 1'b1;
              reg_we   <= 1'b0;
              reg_addr <= addr;
              phase    <= PH_HDR;
              state    <= S_RD;
            end
            default: begin
              reg_req   <= 1'b1;
              reg_we    <= 1'b1;
              reg_addr  <= addr;
              reg_wdata <= ram_rdata;
              cnt       <= cnt - 1'b1;
              phase     <= (cnt == 32'd1) ? PH_HDR : PH_BLK;
              if (op == OP_BLK_INC) addr <= addr + RADDR_W'(4);
              state     <= S_BUS;
            end
          endcase
        end
        S_RD: if (reg_ready) begin
          reg_we    <= 1'b1;
          reg_wdata <= rmw_merge(reg_rdata, mask_q, data_q);
          state     <= S_BUS;
        end
        S_BUS: if (reg_ready) begin
          reg_req <= 1'b0;
          state   <= S_FETCH;
        end
        S_DONE: begin
          irq   <= sel;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
  import cse_pkg::*;
#(
  parameter int RAM_DEPTH = 256,
  localparam int AW = $clog2(RAM_DEPTH),
  localparam int LW = AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ram_we,
  input  logic [AW-1:0]      ram_waddr,
  input  logic [WORD_W-1:0]  ram_wdata,
  input  logic               start,
  input  logic [AW-1:0]      start_offset,
  input  logic [LW-1:0]      start_len,
  input  logic [1:0]         start_irq_sel,
  input  logic               start_ext_trig,
  input  logic               ext_flush,
  output logic               busy,
  output logic [1:0]         irq,
  output logic               reg_req,
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0]  reg_wdata,
  input  logic               reg_ready,
  input  logic [WORD_W-1:0]  reg_rdata
);
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_word;

  cse_cmd_ram #(.DEPTH(RAM_DEPTH), .W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  cse_sequencer #(.AW(AW)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .start_offset   (start_offset),
    .start_len      (start_len),
    .start_irq_sel  (start_irq_sel),
    .start_ext_trig (start_ext_trig),
    .ext_flush      (ext_flush),
    .ram_raddr      (rd_addr),
    .ram_rdata      (rd_word),
    .busy           (busy),
    .irq            (irq),
    .reg_req        (reg_req),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_ready      (reg_ready),
    .reg_rdata      (reg_rdata)
  );
endmodule

// File: rtl/cse_checker.sv
module cse_checker (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic [1:0]  irq,
  input logic        reg_req,
  input logic        reg_we,
  input logic [19:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        reg_ready
);
  p_bus_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ready) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_req);

  p_irq_at_end_r10: assert property (@(posedge clk) disable iff (rst)
    (irq != 2'b00) |-> (!busy && $past(busy)));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (irq != 2'b00) |=> (irq == 2'b00));

  p_rmw_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_we && reg_ready) |=> (reg_req && reg_we && $stable(reg_addr)));
endmodule

bind cmd_stream_exec cse_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .irq       (irq),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_ready (reg_ready)
);

// File: tb/cmd_stream_exec_test.sv
`timescale 1ns/1ps
module cmd_stream_exec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ram_we = 1'b0;
  logic [7:0]  ram_waddr = '0;
  logic [31:0] ram_wdata = '0;
  logic        start = 1'b0;
  logic [7:0]  start_offset = '0;
  logic [8:0]  start_len = '0;
  logic [1:0]  start_irq_sel = '0;
  logic        start_ext_trig = 1'b0;
  logic        ext_flush = 1'b0;
  logic        busy;
  logic [1:0]  irq;
  logic        reg_req, reg_we;
  logic [19:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_ready = 1'b0;
  logic [31:0] reg_rdata = '0;

  cmd_stream_exec uut (.*);

  always #2.5 clk = ~clk;

  logic [31:0] cm [256];
  logic [31:0] bregs [64];
  logic [31:0] eregs [64];
  int nwr, ewr, checks, fails, wait_cnt;

  // register bus responder with random ready delay
  initial begin
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (reg_ready) reg_ready = 1'b0;
      else if (reg_req) begin
        if (wait_cnt == 0) begin
          if (reg_we) begin bregs[reg_addr[7:2]] = reg_wdata; nwr++; end
          else reg_rdata = bregs[reg_addr[7:2]];
          reg_ready = 1'b1;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [3:0] op, input logic [19:0] a);
    return {op, 8'h5A, a};  // junk in bits 27:20 (R1)
  endfunction

  task automatic ram_put(input int a, input logic [31:0] d);
    ram_we = 1'b1; ram_waddr = 8'(a % 256); ram_wdata = d; cm[a % 256] = d;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  task automatic prep_regs();
    for (int i = 0; i < 64; i++) begin
      logic [31:0] v = $urandom;
      bregs[i] = v; eregs[i] = v;
    end
    nwr = 0; ewr = 0;
  endtask

  function automatic void e_wr(input logic [19:0] a, input logic [31:0] d);
    eregs[a[7:2]] = d; ewr++;
  endfunction

  // independent model of the command semantics
  function automatic void model_run(input int off, input int len);
    int i = 0;
    while (i < len) begin
      logic [31:0] h = cm[(off + i) % 256];
      logic [19:0] a = h[19:0];
      logic [31:0] m, d, n;
      i++;
      case (h[31:28])
        4'd1: if (i < len) begin d = cm[(off + i) % 256]; i++; e_wr(a, d); end
        4'd2: if (i < len) begin
          m = cm[(off + i) % 256]; i++;
          if (i < len) begin
            d = cm[(off + i) % 256]; i++;
            e_wr(a, (eregs[a[7:2]] & m) | d);
          end
        end
        4'd3, 4'd4: if (i < len) begin
          n = cm[(off + i) % 256]; i++;
          while (n != 0 && i < len) begin
            d = cm[(off + i) % 256]; i++;
            e_wr(a, d);
            if (h[31:28] == 4'd4) a = a + 20'd4;
            n--;
          end
        end
        default: ;
      endcase
    end
  endfunction

  task automatic start_run(input int off, input int len, input logic [1:0] s, input bit trig);
    start = 1'b1; start_offset = 8'(off); start_len = 9'(len);
    start_irq_sel = s; start_ext_trig = trig;
    @(negedge clk);
    start = 1'b0; start_ext_trig = 1'b0;
  endtask

  task automatic wait_done(output logic [1:0] q);
    while (busy) @(negedge clk);
    q = irq;
  endtask

  task automatic judge(input string req, input logic [1:0] q, input logic [1:0] s);
    int bad = 0;
    for (int i = 0; i < 64; i++) if (bregs[i] !== eregs[i]) bad++;
    chk(bad == 0, req, "register file mismatches", 64'(bad), 64'd0);
    chk(nwr == ewr, req, "write count", 64'(nwr), 64'(ewr));
    chk(q == s, "R10", "irq code", 64'(q), 64'(s));
    @(negedge clk);
    chk(irq == 2'b00, "R10", "irq width", 64'(irq), 64'd0);
  endtask

  task automatic do_case(input string req, input int off, input int len, input logic [1:0] s);
    logic [1:0] q;
    model_run(off, len);
    start_run(off, len, s, 1'b0);
    wait_done(q);
    judge(req, q, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] q;
    void'($urandom(32'd1357));
    checks = 0; fails = 0; nwr = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && irq == 0 && reg_req == 0, "R13", "reset outputs",
        {61'd0, busy, irq}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1, R2: single write with junk header bits
    prep_regs();
    ram_put(0, hdr(4'd1, 20'h00010)); ram_put(1, 32'hCAFE0001);
    do_case("R2", 0, 2, 2'd1);
    chk(bregs[4] == 32'hCAFE0001, "R1", "written value", 64'(bregs[4]), 64'hCAFE0001);

    // R3: read-modify-write
    prep_regs();
    ram_put(4, hdr(4'd2, 20'h00020)); ram_put(5, 32'hFFFF0000); ram_put(6, 32'h00001234);
    do_case("R3", 4, 3, 2'd2);

    // R4: fixed-address block
    prep_regs();
    ram_put(10, hdr(4'd3, 20'h00030)); ram_put(11, 32'd3);
    ram_put(12, 32'h11); ram_put(13, 32'h22); ram_put(14, 32'h33);
    do_case("R4", 10, 5, 2'd1);
    chk(bregs[12] == 32'h33, "R4", "last data kept", 64'(bregs[12]), 64'h33);

    // R5: incrementing block
    prep_regs();
    ram_put(20, hdr(4'd4, 20'h00040)); ram_put(21, 32'd4);
    for (int k = 0; k < 4; k++) ram_put(22 + k, 32'hA0 + k);
    do_case("R5", 20, 6, 2'd2);

    // R6: no-op and unknown opcodes skipped one word each
    prep_regs();
    ram_put(30, hdr(4'd0, 20'h0)); ram_put(31, hdr(4'd15, 20'h0)); ram_put(32, hdr(4'd5, 20'h0));
    ram_put(33, hdr(4'd1, 20'h00008)); ram_put(34, 32'h600D600D);
    do_case("R6", 30, 5, 2'd1);

    // R7: zero-count block
    prep_regs();
    ram_put(40, hdr(4'd4, 20'h00050)); ram_put(41, 32'd0);
    ram_put(42, hdr(4'd1, 20'h00054)); ram_put(43, 32'h77);
    do_case("R7", 40, 4, 2'd2);

    // R8: truncation and RAM wrap
    prep_regs();
    ram_put(254, hdr(4'd4, 20'h00060)); ram_put(255, 32'd5);
    ram_put(0, 32'hB0); ram_put(1, 32'hB1); ram_put(2, 32'hB2);
    do_case("R8", 254, 4, 2'd1);

    // R10: zero-length run
    prep_regs();
    do_case("R10", 50, 0, 2'd3);

    // R11: idle flush has no effect
    ext_flush = 1'b1; @(negedge clk); ext_flush = 1'b0; @(negedge clk);
    chk(busy == 0 && nwr == 0, "R11", "idle flush", {63'd0, busy}, 64'd0);

    // R11: external trigger waits for flush
    prep_regs();
    ram_put(60, hdr(4'd1, 20'h00070)); ram_put(61, 32'hF1F1);
    model_run(60, 2);
    start_run(60, 2, 2'd1, 1'b1);
    repeat (8) @(negedge clk);
    chk(busy == 1 && nwr == 0, "R11", "held before flush", 64'(nwr), 64'd0);
    ext_flush = 1'b1; @(negedge clk); ext_flush = 1'b0;
    wait_done(q);
    judge("R11", q, 2'd1);

    // R12: start while busy ignored
    prep_regs();
    ram_put(70, hdr(4'd4, 20'h00080)); ram_put(71, 32'd6);
    for (int k = 0; k < 6; k++) ram_put(72 + k, 32'hC0 + k);
    ram_put(90, hdr(4'd1, 20'h000F0)); ram_put(91, 32'hDEAD);
    model_run(70, 8);
    start_run(70, 8, 2'd2, 1'b0);
    repeat (3) @(negedge clk);
    start_run(90, 2, 2'd3, 1'b0);
    wait_done(q);
    judge("R12", q, 2'd2);

    // R12: start accepted in the completion cycle
    prep_regs();
    ram_put(100, hdr(4'd2, 20'h00090)); ram_put(101, 32'h0F0F0F0F); ram_put(102, 32'h10000000);
    ram_put(110, hdr(4'd1, 20'h00090)); ram_put(111, 32'h12345678);
    model_run(100, 3);
    model_run(110, 2);
    start_run(100, 3, 2'd1, 1'b0);
    wait_done(q);
    chk(q == 2'd1, "R10", "first irq code", 64'(q), 64'd1);
    start_run(110, 2, 2'd2, 1'b0);
    wait_done(q);
    judge("R12", q, 2'd2);

    // random programs
    for (int r = 0; r < 24; r++) begin
      int off = $urandom % 256;
      int n = 0;
      int len;
      prep_regs();
      for (int c = 0; c < 8; c++) begin
        int kind = $urandom % 7;
        logic [19:0] a = 20'($urandom);
        case (kind)
          1: begin ram_put(off + n, hdr(4'd1, a)); ram_put(off + n + 1, $urandom); n += 2; end
          2: begin ram_put(off + n, hdr(4'd2, a)); ram_put(off + n + 1, $urandom);
                   ram_put(off + n + 2, $urandom); n += 3; end
          3, 4: begin
            int cnt = $urandom % 5;
            ram_put(off + n, hdr(4'(kind), a)); ram_put(off + n + 1, 32'(cnt)); n += 2;
            for (int k = 0; k < cnt; k++) begin ram_put(off + n, $urandom); n++; end
          end
          5: begin ram_put(off + n, hdr(4'd9, a)); n++; end
          default: begin ram_put(off + n, hdr(4'd0, a)); n++; end
        endcase
      end
      len = n;
      if ($urandom % 4 == 0) len = n - ($urandom % 3);
      if (len < 0) len = 0;
      do_case("R8", off, len, 2'($urandom % 4));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule